// File: doc/BRIEF.md
# Command Packet Framer

The framer sits at the front of a command processor. It takes a flat stream of 32-bit command words on a valid/ready input and cuts it into packets. The packet kind comes from the top two bits of each header word. The framer removes the header and sends each payload word on with tags: the packet kind, the opcode of an opcoded command, the register index of a register-write burst, and a flag that marks the final word. Nothing is executed here. A consumer downstream reads the tags and applies the words.

The kinds it recognises are register-write bursts (kind 0), one-word fillers (kind 2) and opcoded commands (kind 3). For bursts and commands, the header holds a payload count biased by one. A no-op command is swallowed whole. A header of the unused kind 1 sets an error flag that stays set, and the word after it is taken as a fresh header. Output backpressure stalls the input, and no word is lost or repeated.

Top module: `cmd_pkt_framer`

## Requirements
- R1: After reset, `out_valid` is 0, `err_flag` is 0 and `in_ready` is 1.
- R2: A kind-3 header (bits 31:30 = 3) with count field c (bits 29:16) is followed by c+1 payload words. Each payload word leaves unchanged with `out_kind`=3, `out_opcode` = header bits 15:8, `out_shader` = header bit 1, `out_pred` = header bit 0 and `out_idx`=0. The header itself is not emitted.
- R3: `out_last` is 1 on the final payload word of a kind-0 or kind-3 packet and 0 on every other payload word. The input word that follows the final payload word is decoded as a header.
- R4: A kind-0 header (bits 31:30 = 0) with base b (bits 15:0) and count c (bits 29:16) is followed by c+1 payload words. Payload word k leaves with `out_kind`=0, `out_idx` = (b+k) mod 2^16, `out_opcode`=0, `out_shader`=0 and `out_pred`=0.
- R5: A kind-2 word (bits 31:30 = 2) is emitted once, unchanged, with `out_kind`=2, `out_last`=1 and all other tags 0. It has no payload.
- R6: A kind-3 packet whose opcode is 0x10 is consumed completely and produces no output word.
- R7: A kind-1 word (bits 31:30 = 1) produces no output and sets `err_flag`. The flag stays 1 until reset. The next input word is decoded as a header.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and every output port holds its value. Across any ready pattern, the output sequence equals the sequence expected from the input, with no word missing or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Framer can accept a word this cycle |
| in_word | input | 32 | Command word |
| out_valid | output | 1 | Tagged word available |
| out_ready | input | 1 | Consumer accepts the tagged word |
| out_word | output | 32 | Payload word, or the filler word itself |
| out_kind | output | 2 | Packet kind the word belongs to |
| out_opcode | output | 8 | Opcode of a kind-3 packet, else 0 |
| out_idx | output | 16 | Register index of a kind-0 payload word, else 0 |
| out_last | output | 1 | Final word of its packet |
| out_shader | output | 1 | Shader flag from a kind-3 header |
| out_pred | output | 1 | Predicate flag from a kind-3 header |
| err_flag | output | 1 | Sticky flag for a kind-1 word |

## Verification
Two events can fall in the same cycle: a packet's final payload word waits in the output register under backpressure while the next header is already offered at the input. A filler can also follow a final word directly. The bench forces both overlaps. It sends packets back to back with no gaps and drives `out_ready` from a pseudo-random pattern and from long stall stretches. Every emitted word is compared in order against a list the bench computes arithmetically from the headers it built. Any boundary that slips by one word shows up as a wrong tag, a wrong index or a missing or extra word.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
   typedef enum logic [1:0] {
      PK_REGS = 2'd0,
      PK_BAD  = 2'd1,
      PK_FILL = 2'd2,
      PK_CMD  = 2'd3
   } pkt_kind_e;
endpackage

// File: rtl/cpf_hdr_decode.sv
module cpf_hdr_decode
   import cpf_pkg::*;
#(
   parameter int          WORD_W   = 32,
   parameter int          CNT_W    = 14,
   parameter int          IDX_W    = 16,
   parameter int          OP_W     = 8,
   parameter logic [7:0]  NOP_OP   = 8'h10,
   parameter bit          DROP_NOP = 1'b1
) (
   input  logic [WORD_W-1:0] hdr_word,
   output pkt_kind_e         dec_kind,
   output logic [CNT_W-1:0]  dec_cnt,
   output logic [IDX_W-1:0]  dec_base,
   output logic [OP_W-1:0]   dec_op,
   output logic              dec_shader,
   output logic              dec_pred,
   output logic              dec_drop
);
   localparam int TYPE_LSB = WORD_W - 2;
   localparam int CNT_LSB  = TYPE_LSB - CNT_W;
   localparam int OP_LSB   = 8;

   if (CNT_LSB != IDX_W) begin : g_bad_layout
      $error("count field must sit directly above the register base");
   end
   if (OP_LSB + OP_W > CNT_LSB) begin : g_bad_op
      $error("opcode field overlaps the count field");
   end

   assign dec_kind   = pkt_kind_e'(hdr_word[WORD_W-1 -: 2]);
   assign dec_cnt    = hdr_word[CNT_LSB +: CNT_W];
   assign dec_base   = hdr_word[IDX_W-1:0];
   assign dec_op     = hdr_word[OP_LSB +: OP_W];
   assign dec_shader = hdr_word[1];
   assign dec_pred   = hdr_word[0];

   logic unused_rsvd;
   assign unused_rsvd = ^hdr_word[OP_LSB-1:2];

   if (DROP_NOP) begin : g_drop_nop
      assign dec_drop = (dec_kind == PK_CMD) && (dec_op == OP_W'(NOP_OP));
   end else begin : g_keep_nop
      assign dec_drop = 1'b0;
   end
endmodule

// File: rtl/cpf_seq.sv
module cpf_seq
   import cpf_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int CNT_W  = 14,
   parameter int IDX_W  = 16,
   parameter int OP_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [WORD_W-1:0] word,
   input  pkt_kind_e         dec_kind,
   input  logic [CNT_W-1:0]  dec_cnt,
   input  logic [IDX_W-1:0]  dec_base,
   input  logic [OP_W-1:0]   dec_op,
   input  logic              dec_shader,
   input  logic              dec_pred,
   input  logic              dec_drop,
   output logic              emit,
   output logic [WORD_W-1:0] e_word,
   output pkt_kind_e         e_kind,
   output logic [OP_W-1:0]   e_op,
   output logic [IDX_W-1:0]  e_idx,
   output logic              e_last,
   output logic              e_shader,
   output logic              e_pred,
   output logic              err
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

   logic             in_body;
   logic [CNT_W-1:0] rem;
   pkt_kind_e        cur_kind;
   logic [OP_W-1:0]  cur_op;
   logic [IDX_W-1:0] cur_idx;
   logic             cur_drop;
   logic             cur_shader;
   logic             cur_pred;
   logic             body_end;

   assign body_end = (rem == '0);

   always_comb begin
      emit     = 1'b0;
      e_word   = word;
      e_kind   = PK_FILL;
      e_op     = '0;
      e_idx    = '0;
      e_last   = 1'b1;
      e_shader = 1'b0;
      e_pred   = 1'b0;
      if (take) begin
         if (in_body) begin
            emit     = !cur_drop;
            e_kind   = cur_kind;
            e_op     = cur_op;
            e_idx    = cur_idx;
            e_last   = body_end;
            e_shader = cur_shader;
            e_pred   = cur_pred;
         end else if (dec_kind == PK_FILL) begin
            emit = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_body    <= 1'b0;
         rem        <= '0;
         cur_kind   <= PK_REGS;
         cur_op     <= '0;
         cur_idx    <= '0;
         cur_drop   <= 1'b0;
         cur_shader <= 1'b0;
         cur_pred   <= 1'b0;
         err        <= 1'b0;
      end else if (take) begin
         if (in_body) begin
            rem <= rem - CNT_ONE;
            if (cur_kind == PK_REGS) begin
               cur_idx <= cur_idx + IDX_ONE;
            end
            if (body_end) begin
               in_body <= 1'b0;
            end
         end else begin
            unique case (dec_kind)
               PK_REGS: begin
                  in_body    <= 1'b1;
                  rem        <= dec_cnt;
                  cur_kind   <= PK_REGS;
                  cur_op     <= '0;
                  cur_idx    <= dec_base;
                  cur_drop   <= 1'b0;
                  cur_shader <= 1'b0;
                  cur_pred   <= 1'b0;
               end
               PK_CMD: begin
                  in_body    <= 1'b1;
                  rem        <= dec_cnt;
                  cur_kind   <= PK_CMD;
                  cur_op     <= dec_op;
                  cur_idx    <= '0;
                  cur_drop   <= dec_drop;
                  cur_shader <= dec_shader;
                  cur_pred   <= dec_pred;
               end
               PK_BAD:  err <= 1'b1;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/cpf_out_reg.sv
module cpf_out_reg
   import cpf_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int IDX_W  = 16,
   parameter int OP_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] d_word,
   input  pkt_kind_e         d_kind,
   input  logic [OP_W-1:0]   d_op,
   input  logic [IDX_W-1:0]  d_idx,
   input  logic              d_last,
   input  logic              d_shader,
   input  logic              d_pred,
   input  logic              q_ready,
   output logic              room,
   output logic              q_valid,
   output logic [WORD_W-1:0] q_word,
   output pkt_kind_e         q_kind,
   output logic [OP_W-1:0]   q_op,
   output logic [IDX_W-1:0]  q_idx,
   output logic              q_last,
   output logic              q_shader,
   output logic              q_pred
);
   assign room = !q_valid || q_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid  <= 1'b0;
         q_word   <= '0;
         q_kind   <= PK_REGS;
         q_op     <= '0;
         q_idx    <= '0;
         q_last   <= 1'b0;
         q_shader <= 1'b0;
         q_pred   <= 1'b0;
      end else if (load) begin
         q_valid  <= 1'b1;
         q_word   <= d_word;
         q_kind   <= d_kind;
         q_op     <= d_op;
         q_idx    <= d_idx;
         q_last   <= d_last;
         q_shader <= d_shader;
         q_pred   <= d_pred;
      end else if (q_ready) begin
         q_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/cmd_pkt_framer.sv
module cmd_pkt_framer
   import cpf_pkg::*;
#(
   parameter int         WORD_W   = 32,
   parameter int         CNT_W    = 14,
   parameter int         IDX_W    = 16,
   parameter int         OP_W     = 8,
   parameter logic [7:0] NOP_OP   = 8'h10,
   parameter bit         DROP_NOP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_word,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_word,
   output logic [1:0]        out_kind,
   output logic [OP_W-1:0]   out_opcode,
   output logic [IDX_W-1:0]  out_idx,
   output logic              out_last,
   output logic              out_shader,
   output logic              out_pred,
   output logic              err_flag
);
   if (WORD_W != 32) begin : g_bad_word
      $error("command words must be 32 bits wide");
   end
   if (OP_W != 8) begin : g_bad_opw
      $error("opcode field must be 8 bits wide");
   end

   pkt_kind_e        dec_kind;
   logic [CNT_W-1:0] dec_cnt;
   logic [IDX_W-1:0] dec_base;
   logic [OP_W-1:0]  dec_op;
   logic             dec_shader, dec_pred, dec_drop;

   logic              take, emit;
   logic [WORD_W-1:0] e_word;
   pkt_kind_e         e_kind, q_kind;
   logic [OP_W-1:0]   e_op;
   logic [IDX_W-1:0]  e_idx;
   logic              e_last, e_shader, e_pred;

   assign take = in_valid && in_ready;

   cpf_hdr_decode #(
      .WORD_W(WORD_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .OP_W(OP_W),
      .NOP_OP(NOP_OP), .DROP_NOP(DROP_NOP)
   ) u_dec (
      .hdr_word  (in_word),
      .dec_kind  (dec_kind),
      .dec_cnt   (dec_cnt),
      .dec_base  (dec_base),
      .dec_op    (dec_op),
      .dec_shader(dec_shader),
      .dec_pred  (dec_pred),
      .dec_drop  (dec_drop)
   );

   cpf_seq #(
      .WORD_W(WORD_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .OP_W(OP_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .word      (in_word),
      .dec_kind  (dec_kind),
      .dec_cnt   (dec_cnt),
      .dec_base  (dec_base),
      .dec_op    (dec_op),
      .dec_shader(dec_shader),
      .dec_pred  (dec_pred),
      .dec_drop  (dec_drop),
      .emit      (emit),
      .e_word    (e_word),
      .e_kind    (e_kind),
      .e_op      (e_op),
      .e_idx     (e_idx),
      .e_last    (e_last),
      .e_shader  (e_shader),
      .e_pred    (e_pred),
      .err       (err_flag)
   );

   cpf_out_reg #(
      .WORD_W(WORD_W), .IDX_W(IDX_W), .OP_W(OP_W)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (emit),
      .d_word  (e_word),
      .d_kind  (e_kind),
      .d_op    (e_op),
      .d_idx   (e_idx),
      .d_last  (e_last),
      .d_shader(e_shader),
      .d_pred  (e_pred),
      .q_ready (out_ready),
      .room    (in_ready),
      .q_valid (out_valid),
      .q_word  (out_word),
      .q_kind  (q_kind),
      .q_op    (out_opcode),
      .q_idx   (out_idx),
      .q_last  (out_last),
      .q_shader(out_shader),
      .q_pred  (out_pred)
   );

   assign out_kind = q_kind;
endmodule

// File: rtl/cpf_checker.sv
module cpf_checker #(
   parameter int         WORD_W   = 32,
   parameter int         IDX_W    = 16,
   parameter int         OP_W     = 8,
   parameter logic [7:0] NOP_OP   = 8'h10,
   parameter bit         DROP_NOP = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [WORD_W-1:0] out_word,
   input logic [1:0]        out_kind,
   input logic [OP_W-1:0]   out_opcode,
   input logic [IDX_W-1:0]  out_idx,
   input logic              out_last,
   input logic              out_shader,
   input logic              out_pred,
   input logic              err_flag
);
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_kind)
                                     && $stable(out_idx) && $stable(out_last)));

   p_no_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   p_filler_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind == 2'd2) |-> (out_last && out_opcode == '0 && out_idx == '0));

   p_regs_untagged_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind == 2'd0) |-> (out_opcode == '0 && !out_shader && !out_pred));

   p_nop_hidden_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind == 2'd3) |-> (!DROP_NOP || out_opcode != OP_W'(NOP_OP)));

   p_no_bad_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_kind != 2'd1));

   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);
endmodule

bind cmd_pkt_framer cpf_checker #(
   .WORD_W(WORD_W), .IDX_W(IDX_W), .OP_W(OP_W), .NOP_OP(NOP_OP), .DROP_NOP(DROP_NOP)
) u_cpf_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_word  (out_word),
   .out_kind  (out_kind),
   .out_opcode(out_opcode),
   .out_idx   (out_idx),
   .out_last  (out_last),
   .out_shader(out_shader),
   .out_pred  (out_pred),
   .err_flag  (err_flag)
);

// File: tb/test_cmd_pkt_framer.sv
module test_cmd_pkt_framer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_word = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] out_word;
   logic [1:0]  out_kind;
   logic [7:0]  out_opcode;
   logic [15:0] out_idx;
   logic        out_last, out_shader, out_pred, err_flag;

   always #10 clk = ~clk;

   cmd_pkt_framer i_cmd_pkt_framer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
      .out_word(out_word), .out_kind(out_kind), .out_opcode(out_opcode),
      .out_idx(out_idx), .out_last(out_last), .out_shader(out_shader),
      .out_pred(out_pred), .err_flag(err_flag)
   );

   int total = 0;
   int bad   = 0;

   logic [31:0] stim [0:511];
   logic [63:0] expv [0:511];
   int          n_stim = 0;
   int          n_exp  = 0;
   logic [31:0] pay    = 32'hA500_0000;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] pack(input logic [31:0] w, input logic [1:0] k,
                                        input logic [7:0] op, input logic [15:0] idx,
                                        input logic l, input logic s, input logic p);
      return {3'b0, w, k, op, idx, l, s, p};
   endfunction

   task automatic add_cmd(input int cnt, input logic [7:0] op, input logic s, input logic p);
      stim[n_stim++] = {2'b11, 14'(cnt), op, 6'b0, s, p};
      for (int k = 0; k <= cnt; k++) begin
         pay = pay + 32'h0001_0003;
         stim[n_stim++] = pay;
         if (op != 8'h10) expv[n_exp++] = pack(pay, 2'd3, op, 16'h0, (k == cnt), s, p);
      end
   endtask

   task automatic add_regs(input int cnt, input logic [15:0] base);
      stim[n_stim++] = {2'b00, 14'(cnt), base};
      for (int k = 0; k <= cnt; k++) begin
         pay = pay + 32'h0001_0003;
         stim[n_stim++] = pay;
         expv[n_exp++] = pack(pay, 2'd0, 8'h0, base + 16'(k), (k == cnt), 1'b0, 1'b0);
      end
   endtask

   task automatic add_fill(input logic [29:0] rsv);
      stim[n_stim++] = {2'b10, rsv};
      expv[n_exp++] = pack({2'b10, rsv}, 2'd2, 8'h0, 16'h0, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic add_bad(input logic [29:0] rsv);
      stim[n_stim++] = {2'b01, rsv};
   endtask

   task automatic build();
      logic [7:0] ops [0:2];
      ops[0] = 8'h37; ops[1] = 8'h69; ops[2] = 8'hA5;
      for (int c = 0; c < 5; c++)
         for (int o = 0; o < 3; o++)
            add_cmd(c, ops[o], c[1], c[0]);
      add_regs(3, 16'h0040);
      add_regs(3, 16'hFFFE);
      add_fill(30'h0123_4567);
      add_fill(30'h3FFF_FFFF);
      add_cmd(0, 8'h10, 1'b0, 1'b0);
      add_cmd(3, 8'h10, 1'b1, 1'b1);
      add_cmd(1, 8'h42, 1'b1, 1'b0);
      add_bad(30'h0000_0055);
      add_cmd(1, 8'h10, 1'b0, 1'b0);
      add_bad(30'h2AAA_AAAA);
      add_cmd(2, 8'h77, 1'b0, 1'b1);
      add_regs(0, 16'h1234);
      add_fill(30'h0);
      add_regs(5, 16'hFFFD);
      add_cmd(0, 8'hFF, 1'b1, 1'b1);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
      check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
      check(err_flag == 1'b0, "R1", "err_flag after reset", 64'(err_flag), 64'd0);
   endtask

   task automatic run_phase(input int mode);
      int          in_idx = 0;
      int          rd = 0;
      int          cyc = 0;
      bit          stalled = 0;
      logic [63:0] held = '0;
      logic [15:0] lf = 16'hACE1 ^ 16'(mode);
      logic [63:0] act;
      string       tag;
      do_reset();
      while (!(in_idx == n_stim && rd == n_exp)) begin
         @(negedge clk);
         cyc++;
         if (cyc > 20000) begin
            check(1'b0, "R8", "watchdog expired", 64'(rd), 64'(n_exp));
            break;
         end
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         case (mode)
            0: begin in_valid = (in_idx < n_stim); out_ready = 1'b1; end
            1: begin in_valid = (in_idx < n_stim) && lf[3]; out_ready = lf[7] | lf[1]; end
            default: begin in_valid = (in_idx < n_stim); out_ready = (cyc % 6 == 0); end
         endcase
         in_word = (in_idx < n_stim) ? stim[in_idx] : 32'h0;
         #1;
         act = pack(out_word, out_kind, out_opcode, out_idx, out_last, out_shader, out_pred);
         if (stalled) begin
            check(out_valid && act == held, "R8", "held output under stall", act, held);
         end
         if (out_valid && !out_ready) begin
            check(!in_ready, "R8", "in_ready during stall", 64'(in_ready), 64'd0);
         end
         stalled = out_valid && !out_ready;
         held = act;
         if (out_valid && out_ready) begin
            if (rd >= n_exp) begin
               check(1'b0, "R8", "extra output word", act, 64'd0);
            end else begin
               case (expv[rd][26:25])
                  2'd0:    tag = "R4 R3";
                  2'd2:    tag = "R5";
                  default: tag = "R2 R3";
               endcase
               check(act == expv[rd], tag, $sformatf("output %0d", rd), act, expv[rd]);
               rd++;
            end
         end
         if (in_valid && in_ready) in_idx++;
      end
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1;
      repeat (4) @(negedge clk);
      check(out_valid == 1'b0, "R6", "no surplus output after stream", 64'(out_valid), 64'd0);
      check(rd == n_exp, "R6", "output word count", 64'(rd), 64'(n_exp));
      check(err_flag == 1'b1, "R7", "sticky error after kind-1 word", 64'(err_flag), 64'd1);
   endtask

   initial begin
      build();
      for (int m = 0; m < 3; m++) run_phase(m);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule